// File: doc/BRIEF.md
# Two-Wire Write-Only Configuration Receiver

This block is a slave on a two-wire serial bus that only accepts writes. A bus master sends a fixed frame of ten bytes: an address byte, a command byte, a count byte, and then seven data bytes. The block checks the address byte against one fixed value. When the address matches, the last four data bytes are loaded into four 8-bit control registers. These registers drive the configuration of the clock-generation logic next to the block.

The registers come out of reset holding parameter defaults, so a system that never writes to the block still works. Both bus lines are sampled with the system clock and passed through a glitch filter. Start and stop conditions are recovered from the filtered lines. The block acknowledges a byte by driving an open-drain pull-down on the data line.

Top module: `cfg_sreg_rx`

## Requirements
- R1: After reset, ctl0_o=8'h02 (bits [1:0]=2'b10, spread enabled), ctl1_o=8'hF7, ctl2_o=8'hEF and ctl3_o=8'h23.
- R2: Only an address byte of 8'hD2 is accepted (write bit 0 included). With any other address byte, no register changes and no byte of that frame is acknowledged.
- R3: In a matched frame, bytes 7, 8, 9 and 10 (counting from the address byte as byte 1) are loaded into ctl0_o, ctl1_o, ctl2_o and ctl3_o. Bytes 2 to 6 have no effect on any output.
- R4: Bits are taken most significant first: the first data bit clocked in a byte becomes bit 7 of that byte.
- R5: In a matched frame, sda_oe_o is high during the ninth clock of each of bytes 1 to 10. It is low at all other times, which includes any byte after the tenth.
- R6: When a stop condition ends a frame early, every byte that was fully received still takes effect. A byte that was cut off changes nothing, and sda_oe_o is low after the stop.
- R7: A pulse on either line that lasts fewer than FILT_LEN system-clock samples is ignored.
- R8: A repeated start restarts the byte count, so the bytes that follow it are taken as a new frame.
- R9: A later complete frame overwrites all four registers again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as seen on the wire |
| sda_oe_o | output | 1 | High pulls the data line low (acknowledge) |
| ctl0_o | output | 8 | Control register 0 (mode bits [1:0]) |
| ctl1_o | output | 8 | Control register 1 |
| ctl2_o | output | 8 | Control register 2 |
| ctl3_o | output | 8 | Control register 3 |

## Verification
Data values such as 8'h01 and 8'h80 separate the two bit orders. A design that shifts least significant bit first swaps them, and one that counts the ignored bytes wrongly loads a neighbouring byte. A stop inside the ninth byte must keep bytes 7 and 8 and leave bytes 9 and 10 unchanged, which catches designs that commit partial bytes or drop completed ones. A single-sample pulse on SCL is injected in the middle of a byte; a weak filter would add a bit and corrupt that register. The bench also sends a wrong address, an eleventh byte, and a repeated start after two bytes, which catch designs that acknowledge too widely or keep counting across a restart.

// File: rtl/cfg_sreg_pkg.sv
package cfg_sreg_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned N_BYTES   = 10;  // address + command + count + 7 data
  localparam int unsigned FIRST_KEP = 6;   // zero-based frame index of first kept byte
  localparam int unsigned N_REGS    = 4;
endpackage

// File: rtl/cfg_sreg_filt.sv
module cfg_sreg_filt #(
  parameter int unsigned FILT_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FILT_LEN - 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_TOP) begin
        out_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = out_q;

  // R7: output follows only a level the synchronizer has shown
  p_filt_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q != $past(out_q)) |-> ($past(sync_q[1]) == out_q));
endmodule

// File: rtl/cfg_sreg_cond.sv
module cfg_sreg_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = ~scl_q & scl_i;
  assign fall_o  = scl_q & ~scl_i;

  p_start_stop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
endmodule

// File: rtl/cfg_sreg_rx.sv
module cfg_sreg_rx
  import cfg_sreg_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'hD2,
  parameter int unsigned FILT_LEN = 2,
  parameter logic [N_REGS*BYTE_W-1:0] REG_DEF = {8'h23, 8'hEF, 8'hF7, 8'h02}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [7:0] ctl0_o,
  output logic [7:0] ctl1_o,
  output logic [7:0] ctl2_o,
  output logic [7:0] ctl3_o
);
  localparam int unsigned BIT_W = 4;
  localparam int unsigned IDX_W = $clog2(N_BYTES + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W);
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BYTE_W + 1);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(N_BYTES);

  logic [1:0] raw_w, filt_w;
  assign raw_w = {scl_i, sda_i};

  for (genvar l = 0; l < 2; l++) begin : g_filt
    cfg_sreg_filt #(.FILT_LEN(FILT_LEN)) filt_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_w[l]),
      .line_o(filt_w[l])
    );
  end

  logic scl_f, sda_f, start_w, stop_w, rise_w, fall_w;
  assign scl_f = filt_w[1];
  assign sda_f = filt_w[0];

  cfg_sreg_cond cond_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_f),
    .sda_i  (sda_f),
    .start_o(start_w),
    .stop_o (stop_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  logic             active_q, addr_ok_q, oe_q;
  logic [BIT_W-1:0] bit_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       sh_q;
  logic             byte_done;

  assign byte_done = active_q && !start_w && !stop_w && fall_w && (bit_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      addr_ok_q <= 1'b0;
      oe_q      <= 1'b0;
      bit_q     <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
    end else if (start_w) begin
      active_q  <= 1'b1;
      addr_ok_q <= 1'b0;
      oe_q      <= 1'b0;
      bit_q     <= '0;
      idx_q     <= '0;
    end else if (stop_w) begin
      active_q  <= 1'b0;
      oe_q      <= 1'b0;
      bit_q     <= '0;
    end else if (active_q) begin
      if (rise_w && bit_q < LAST_BIT) begin
        sh_q  <= {sh_q[6:0], sda_f};
        bit_q <= bit_q + 1'b1;
      end
      if (fall_w) begin
        if (bit_q == LAST_BIT) begin
          bit_q <= ACK_SLOT;
          if (idx_q == '0) begin
            addr_ok_q <= (sh_q == DEV_ADDR);
            oe_q      <= (sh_q == DEV_ADDR);
          end else begin
            oe_q <= addr_ok_q && (idx_q < IDX_END);
          end
        end else if (bit_q == ACK_SLOT) begin
          oe_q  <= 1'b0;
          bit_q <= '0;
          if (idx_q < IDX_END) idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign sda_oe_o = oe_q;

  logic [7:0] reg_q [N_REGS];

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg_q[k] <= REG_DEF[k*BYTE_W +: BYTE_W];
      end else if (byte_done && addr_ok_q && idx_q == IDX_W'(FIRST_KEP + k)) begin
        reg_q[k] <= sh_q;
      end
    end

    // R2: a register changes only inside an address-matched frame
    p_write_needs_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_q[k] != $past(reg_q[k])) |-> $past(addr_ok_q));
  end

  assign ctl0_o = reg_q[0];
  assign ctl1_o = reg_q[1];
  assign ctl2_o = reg_q[2];
  assign ctl3_o = reg_q[3];

  // R5: acknowledge drive only in the ninth-clock slot
  p_oe_in_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (bit_q == ACK_SLOT));
  // R6: a stop releases the data line
  p_stop_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> !sda_oe_o);
  // R3: frame index never passes the end marker
  p_idx_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_END);
  // R8: a start clears the bit position
  p_start_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (bit_q == '0 && idx_q == '0));
endmodule

// File: tb/cfg_sreg_rx_tb_top.sv
module cfg_sreg_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_line, sda_oe;
  logic [7:0] c0, c1, c2, c3;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign sda_line = sda_oe ? 1'b0 : m_sda;

  cfg_sreg_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .ctl0_o(c0), .ctl1_o(c1), .ctl2_o(c2), .ctl3_o(c3)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] tx_buf [0:15];
  logic       ack_seen [0:15];

  localparam logic [7:0] VEC_FR [0:2][0:9] = '{
    '{8'hD2, 8'h00, 8'h07, 8'h11, 8'h22, 8'h33, 8'hA5, 8'h5A, 8'h01, 8'h80},
    '{8'hD2, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hC3, 8'h3C},
    '{8'hD2, 8'h13, 8'h04, 8'h99, 8'h88, 8'h77, 8'h02, 8'h7E, 8'hE7, 8'h42}
  };
  localparam logic [31:0] VEC_EXP [0:2] = '{32'hA55A0180, 32'h00FFC33C, 32'h027EE742};

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_regs(input string req, input logic [31:0] exp);
    n_run++;
    if ({c0, c1, c2, c3} !== exp) begin
      n_fail++;
      $display("FAIL %s regs got %h expected %h", req, {c0, c1, c2, c3}, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic do_start();
    m_sda = 1'b1; tick(HALF);
    m_scl = 1'b1; tick(HALF);
    m_sda = 1'b0; tick(HALF);
    m_scl = 1'b0;
  endtask

  task automatic do_stop();
    m_sda = 1'b0; tick(HALF);
    m_scl = 1'b1; tick(HALF);
    m_sda = 1'b1; tick(HALF * 2);
  endtask

  // n full bytes, then part_bits bits of tx_buf[n]; glitch on SCL inside byte glb
  task automatic xfer(input int n, input int part_bits, input bit stop, input int glb);
    do_start();
    for (int b = 0; b <= n; b++) begin
      int nb = (b < n) ? 8 : part_bits;
      for (int i = 7; i > 7 - nb; i--) begin
        m_sda = tx_buf[b][i];
        tick(HALF / 2);
        if (b == glb && i == 4) begin
          m_scl = 1'b1; tick(1); m_scl = 1'b0;
        end
        tick(HALF / 2);
        m_scl = 1'b1; tick(HALF);
        m_scl = 1'b0;
      end
      if (b < n) begin
        m_sda = 1'b1; tick(HALF);
        m_scl = 1'b1; tick(HALF / 2);
        ack_seen[b] = (sda_line == 1'b0);
        tick(HALF / 2);
        m_scl = 1'b0;
      end
    end
    if (stop) do_stop();
    tick(HALF);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset defaults
    check_regs("R1", 32'h02F7EF23);
    check_bit("R1 oe", sda_oe, 1'b0);

    // R3 R4 R5 R9: table of full frames
    for (int v = 0; v < 3; v++) begin
      logic all_ack;
      for (int b = 0; b < 10; b++) tx_buf[b] = VEC_FR[v][b];
      xfer(10, 0, 1'b1, -1);
      check_regs("R3/R4/R9", VEC_EXP[v]);
      all_ack = 1'b1;
      for (int b = 0; b < 10; b++) all_ack &= ack_seen[b];
      check_bit("R5 acks", all_ack, 1'b1);
    end

    // R2: wrong address, then read-direction address
    for (int t = 0; t < 2; t++) begin
      logic any_ack;
      tx_buf[0] = (t == 0) ? 8'hD0 : 8'hD3;
      for (int b = 1; b < 10; b++) tx_buf[b] = 8'h66;
      xfer(10, 0, 1'b1, -1);
      any_ack = 1'b0;
      for (int b = 0; b < 10; b++) any_ack |= ack_seen[b];
      check_bit("R2 no ack", any_ack, 1'b0);
      check_regs("R2 unchanged", 32'h027EE742);
    end

    // R5: eleventh byte is not acknowledged
    tx_buf[0] = 8'hD2;
    for (int b = 1; b < 6; b++) tx_buf[b] = 8'h00;
    tx_buf[6] = 8'h10; tx_buf[7] = 8'h20; tx_buf[8] = 8'h30; tx_buf[9] = 8'h40;
    tx_buf[10] = 8'h99;
    xfer(11, 0, 1'b1, -1);
    check_bit("R5 tenth ack", ack_seen[9], 1'b1);
    check_bit("R5 eleventh no ack", ack_seen[10], 1'b0);
    check_regs("R5 regs", 32'h10203040);

    // R6: stop inside ninth byte
    tx_buf[6] = 8'h5A; tx_buf[7] = 8'h3C; tx_buf[8] = 8'hFF;
    xfer(8, 4, 1'b1, -1);
    check_regs("R6 partial", 32'h5A3C3040);
    check_bit("R6 released", sda_oe, 1'b0);

    // R7: one-sample SCL pulse inside byte 8
    tx_buf[6] = 8'h61; tx_buf[7] = 8'h62; tx_buf[8] = 8'h63; tx_buf[9] = 8'h64;
    xfer(10, 0, 1'b1, 7);
    check_regs("R7 glitch", 32'h61626364);

    // R8: repeated start after two bytes
    tx_buf[0] = 8'hD2; tx_buf[1] = 8'h00;
    xfer(2, 0, 1'b0, -1);
    tx_buf[6] = 8'h0F; tx_buf[7] = 8'hF0; tx_buf[8] = 8'h55; tx_buf[9] = 8'hAA;
    xfer(10, 0, 1'b1, -1);
    check_regs("R8 restart", 32'h0FF055AA);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule